// File: doc/BRIEF.md
# Temperature-to-Table Slot Indexer

This block turns a stream of signed temperature samples into the index of a compensation-table slot. The range is split into two-degree windows, with one slot at each end that collects every reading beyond the range. The indexer holds the current slot in a register. It takes in a new sample only when automatic updating is enabled and a sample-valid strobe arrives. A result of 0 to 71 is presented both as a slot offset and as a byte address, which is the offset plus 80h.

Readings that rise move the index into the new window at once. Readings that fall must go one degree past the window edge before the index steps down. A temperature that sits on a boundary therefore does not make the selected table entry flicker.

A manual mode stops the automatic path. In this mode the index is loaded from a register-write port instead, so firmware can force any slot.

Top module: `temp_slot_index`

## Requirements
- R1: While rst_ni is low, and after it until the first accepted sample or write, slot_o is 0 and addr_o is 80h.
- R2: An accepted sample t (8-bit two's complement, 1 °C per LSB) in the range -39..100 selects slot floor((t+41)/2). So -39 and -38 give slot 1, and 99 and 100 give slot 70. addr_o always equals 80h plus slot_o.
- R3: A sample of -41 or below always gives slot 0. A sample of 101 or above always gives slot 71. The index never exceeds 71.
- R4: If the window of a sample is above the current slot, the index moves to that window on the clock edge that accepts the sample.
- R5: If the window of a sample is exactly one below the current slot, and the sample is the top degree of that lower window, the index holds. A reading one degree lower moves the index down. For example, from slot 33 (25..26 °C), a reading of 24 holds and a reading of 23 gives slot 32. From slot 1, -40 holds.
- R6: One accepted sample may move the index by any number of windows in either direction. Hysteresis applies only to the adjacent lower boundary.
- R7: A sample is accepted only when samp_vld_i=1, upd_en_i=1 and man_en_i=0. In every other cycle with no accepted write, slot_o keeps its value.
- R8: When man_en_i=1, samples have no effect, and wr_en_i=1 loads wr_data_i into the index on the next edge. A value above 71 is stored as 71.
- R9: When man_en_i=0, wr_en_i has no effect.
- R10: An accepted sample or write becomes visible on slot_o and addr_o one clock after the edge at which it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_en_i | input | 1 | Automatic update enable |
| samp_vld_i | input | 1 | New temperature sample strobe |
| samp_temp_i | input | 8 | Temperature, two's complement, 1 °C/LSB |
| man_en_i | input | 1 | Manual index mode |
| wr_en_i | input | 1 | Index register write strobe |
| wr_data_i | input | 7 | Index value to write |
| slot_o | output | 7 | Current table slot, 0..71 |
| addr_o | output | 8 | Table byte address, 80h..C7h |

## Verification
A sample strobe and a register write can arrive in the same clock, and exactly one of them may take effect. The bench presents both together, once with manual mode on and once with it off. In each case the sample and the write point at clearly different slots. The check confirms that the index lands on the written value in manual mode and on the sample's window otherwise. The checker also flags any index change in a cycle where neither path was eligible.

// File: rtl/temp_slot_pkg.sv
package temp_slot_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_AUTO  = 2'd1,
    SRC_WRITE = 2'd2
  } slot_src_e;
endpackage

// File: rtl/temp_slot_map.sv
module temp_slot_map #(
  parameter int TEMP_W    = 8,
  parameter int SLOT_W    = 7,
  parameter int NUM_SLOTS = 72,
  parameter int T_MIN     = -40,
  parameter int WIN_DEG   = 2
) (
  input  logic [TEMP_W-1:0] temp_i,
  output logic [SLOT_W-1:0] raw_o
);
  localparam int LAST = NUM_SLOTS - 1;

  int t;
  int q;

  always_comb begin
    t = int'(signed'(temp_i));
    q = 0;
    if (t > T_MIN) begin
      q = (t - T_MIN + WIN_DEG - 1) / WIN_DEG;
      if (q > LAST) q = LAST;
    end
    raw_o = SLOT_W'(q);
  end
endmodule

// File: rtl/temp_slot_hyst.sv
module temp_slot_hyst #(
  parameter int TEMP_W  = 8,
  parameter int SLOT_W  = 7,
  parameter int T_MIN   = -40,
  parameter int WIN_DEG = 2
) (
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [SLOT_W-1:0] raw_i,
  input  logic [SLOT_W-1:0] cur_i,
  output logic [SLOT_W-1:0] nxt_o
);
  int t;
  int thr;

  // stepping down needs the reading one degree below the top of the lower window
  always_comb begin
    t   = int'(signed'(temp_i));
    thr = T_MIN + (int'(cur_i) - 1) * WIN_DEG - 1;
    nxt_o = cur_i;
    if (raw_i > cur_i)                   nxt_o = raw_i;
    else if (raw_i < cur_i && t <= thr)  nxt_o = raw_i;
  end
endmodule

// File: rtl/temp_slot_sel.sv
module temp_slot_sel
  import temp_slot_pkg::*;
#(
  parameter int SLOT_W    = 7,
  parameter int NUM_SLOTS = 72
) (
  input  logic              upd_en_i,
  input  logic              samp_vld_i,
  input  logic              man_en_i,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_data_i,
  input  logic [SLOT_W-1:0] auto_i,
  input  logic [SLOT_W-1:0] cur_i,
  output slot_src_e         src_o,
  output logic [SLOT_W-1:0] nxt_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

  logic [SLOT_W-1:0] wr_sat;

  always_comb begin
    wr_sat = (wr_data_i > LAST) ? LAST : wr_data_i;
    src_o  = SRC_HOLD;
    if (man_en_i) begin
      if (wr_en_i) src_o = SRC_WRITE;
    end else if (upd_en_i && samp_vld_i) begin
      src_o = SRC_AUTO;
    end
    unique case (src_o)
      SRC_AUTO:  nxt_o = auto_i;
      SRC_WRITE: nxt_o = wr_sat;
      default:   nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/temp_slot_index.sv
module temp_slot_index
  import temp_slot_pkg::*;
#(
  parameter int             TEMP_W    = 8,
  parameter int             SLOT_W    = 7,
  parameter int             ADDR_W    = 8,
  parameter int             NUM_SLOTS = 72,
  parameter int             T_MIN     = -40,
  parameter int             WIN_DEG   = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_en_i,
  input  logic              samp_vld_i,
  input  logic [TEMP_W-1:0] samp_temp_i,
  input  logic              man_en_i,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_data_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] raw_slot;
  logic [SLOT_W-1:0] auto_slot;
  logic [SLOT_W-1:0] slot_d;
  slot_src_e         src;

  temp_slot_map #(
    .TEMP_W(TEMP_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
    .T_MIN(T_MIN), .WIN_DEG(WIN_DEG)
  ) map_i (
    .temp_i(samp_temp_i),
    .raw_o (raw_slot)
  );

  temp_slot_hyst #(
    .TEMP_W(TEMP_W), .SLOT_W(SLOT_W), .T_MIN(T_MIN), .WIN_DEG(WIN_DEG)
  ) hyst_i (
    .temp_i(samp_temp_i),
    .raw_i (raw_slot),
    .cur_i (slot_q),
    .nxt_o (auto_slot)
  );

  temp_slot_sel #(
    .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)
  ) sel_i (
    .upd_en_i  (upd_en_i),
    .samp_vld_i(samp_vld_i),
    .man_en_i  (man_en_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .auto_i    (auto_slot),
    .cur_i     (slot_q),
    .src_o     (src),
    .nxt_o     (slot_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            slot_q <= '0;
    else if (src != SRC_HOLD) slot_q <= slot_d;
  end

  assign slot_o = slot_q;
  assign addr_o = BASE_ADDR + ADDR_W'(slot_q);
endmodule

// File: rtl/temp_slot_index_chk.sv
module temp_slot_index_chk #(
  parameter int TEMP_W    = 8,
  parameter int SLOT_W    = 7,
  parameter int NUM_SLOTS = 72,
  parameter int T_MIN     = -40,
  parameter int WIN_DEG   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              upd_en_i,
  input logic              samp_vld_i,
  input logic [TEMP_W-1:0] samp_temp_i,
  input logic              man_en_i,
  input logic              wr_en_i,
  input logic [SLOT_W-1:0] wr_data_i,
  input logic [SLOT_W-1:0] slot_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);
  localparam int HOT  = T_MIN + (NUM_SLOTS - 2) * WIN_DEG + 1;
  localparam int COLD = T_MIN - 1;

  logic take_s, take_w;
  assign take_s = samp_vld_i && upd_en_i && !man_en_i;
  assign take_w = wr_en_i && man_en_i;

  // R3
  slot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o <= LAST);

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_s && !take_w |=> $stable(slot_o));

  // R8
  man_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_w && wr_data_i <= LAST |=> slot_o == $past(wr_data_i));

  // R8
  man_write_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_w && wr_data_i > LAST |=> slot_o == LAST);

  // R3
  hot_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_s && int'(signed'(samp_temp_i)) >= HOT |=> slot_o == LAST);

  // R3
  cold_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_s && int'(signed'(samp_temp_i)) <= COLD |=> slot_o == '0);
endmodule

bind temp_slot_index temp_slot_index_chk #(
  .TEMP_W(TEMP_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
  .T_MIN(T_MIN), .WIN_DEG(WIN_DEG)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .upd_en_i   (upd_en_i),
  .samp_vld_i (samp_vld_i),
  .samp_temp_i(samp_temp_i),
  .man_en_i   (man_en_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .slot_o     (slot_o)
);

// File: tb/temp_slot_index_tb_top.sv
module temp_slot_index_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd_en = 1'b1;
  logic       samp_vld = 1'b0;
  logic [7:0] temp = '0;
  logic       man_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [6:0] wr_data = '0;
  logic [6:0] slot;
  logic [7:0] addr;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  temp_slot_index dut_i (
    .clk_i(clk), .rst_ni(rst_n), .upd_en_i(upd_en), .samp_vld_i(samp_vld),
    .samp_temp_i(temp), .man_en_i(man_en), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .slot_o(slot), .addr_o(addr)
  );

  // {temperature, expected slot}, applied in order from slot 0
  localparam logic [14:0] VEC [22] = '{
    {8'd25,   7'd33},  // R4 jump up
    {8'd24,   7'd33},  // R5 hold on boundary
    {8'd23,   7'd32},  // R5 step down
    {8'd25,   7'd33},  // R4
    {8'd26,   7'd33},  // R2
    {8'd27,   7'd34},  // R4
    {8'd26,   7'd34},  // R5
    {8'd20,   7'd30},  // R6 multi-window drop
    {8'd100,  7'd70},  // R6
    {8'd101,  7'd71},  // R3
    {8'd127,  7'd71},  // R3
    {8'd100,  7'd71},  // R5 top slot hold
    {8'd99,   7'd70},  // R5
    {8'hD9,   7'd1},   // R2 -39
    {8'hD8,   7'd1},   // R5 -40 holds
    {8'hD7,   7'd0},   // R3 -41
    {8'h80,   7'd0},   // R3 -128
    {8'hDA,   7'd1},   // R2 -38
    {8'd0,    7'd20},  // R2
    {8'hFF,   7'd20},  // R2 -1
    {8'hFE,   7'd20},  // R5 -2 holds
    {8'hFD,   7'd19}   // R5 -3
  };

  task automatic check(input logic [6:0] exp, input string req);
    logic [7:0] exp_addr;
    exp_addr = 8'h80 + {1'b0, exp};
    n_cmp++;
    if (slot !== exp || addr !== exp_addr) begin
      n_bad++;
      $display("FAIL %s slot=%0d addr=%h expected slot=%0d addr=%h",
               req, slot, addr, exp, exp_addr);
    end
  endtask

  // presents inputs for one edge, returns at the next falling edge
  task automatic cyc(input logic vld, input logic [7:0] t,
                     input logic we, input logic [6:0] wd);
    samp_vld = vld; temp = t; wr_en = we; wr_data = wd;
    @(negedge clk);
    samp_vld = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(7'd0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(7'd0, "R1 after reset");
    cyc(1'b0, 8'd50, 1'b0, 7'd0);
    check(7'd0, "R1 no sample yet");

    for (int i = 0; i < 22; i++) begin
      cyc(1'b1, VEC[i][14:7], 1'b0, 7'd0);
      check(VEC[i][6:0], $sformatf("R2/R4/R5/R6/R10 vec%0d", i));
    end

    // R7 update disabled
    upd_en = 1'b0;
    cyc(1'b1, 8'd60, 1'b0, 7'd0);
    check(7'd19, "R7 update disabled");
    upd_en = 1'b1;

    // R9 write without manual mode
    cyc(1'b0, 8'd0, 1'b1, 7'd5);
    check(7'd19, "R9 write ignored");

    // R8 manual mode
    man_en = 1'b1;
    cyc(1'b1, 8'd60, 1'b0, 7'd0);
    check(7'd19, "R8 sample ignored in manual");
    cyc(1'b0, 8'd0, 1'b1, 7'd5);
    check(7'd5, "R8 manual write");
    cyc(1'b0, 8'd0, 1'b1, 7'd100);
    check(7'd71, "R8 write saturates");
    cyc(1'b0, 8'd0, 1'b1, 7'd71);
    check(7'd71, "R8 write last slot");

    // R10 same-cycle sample and write
    cyc(1'b1, 8'hD0, 1'b1, 7'd9);
    check(7'd9, "R10 collision manual");
    man_en = 1'b0;
    cyc(1'b1, 8'd60, 1'b1, 7'd3);
    check(7'd50, "R10 collision auto");

    // R1 reset in mid-run, then fresh first sample
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(7'd0, "R1 reset mid-run");
    rst_n = 1'b1;
    @(negedge clk);
    cyc(1'b1, 8'd50, 1'b0, 7'd0);
    check(7'd45, "R4 first sample after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule